// File: doc/BRIEF.md
# SPI FIFO Buffering, Status and Request Unit

This unit sits between a simple register port and an SPI serial engine. It buffers words in both directions: software pushes transmit words through a data register and the engine pops them, while the engine pushes received words and software pops them. Both FIFOs expose their fill level. Each FIFO also has a programmable threshold that drives a level interrupt.

A status word gives the full and empty conditions of both FIFOs and the engine's busy state. Five interrupt sources are collected into a raw vector and a masked vector, and the masked vector is ORed onto a single interrupt line. Three of the sources are sticky error flags: transmit overflow, receive overflow and receive underflow. Software clears them through a write-only clear register.

Two DMA request lines are provided, one per direction. Each is gated by its own enable bit and compared against its own data-level register. Threshold registers refuse values that are not below the FIFO depth, so software can find the depth by writing increasing values and reading them back.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: After reset both levels read 0, all configuration registers read 0, no sticky flag is set and both DMA requests are low.
- R2: Words leave each FIFO in the order they entered. eng_tx_data shows the oldest transmit word. A read of address 1 returns the oldest receive word and removes it.
- R3: Address 3 reads the transmit fill level and address 4 reads the receive fill level. Each ranges from 0 to DEPTH.
- R4: Status at address 2 has these bits: bit0 = eng_busy, bit1 = transmit full, bit2 = transmit empty, bit3 = receive empty, bit4 = receive full.
- R5: A write to address 0 pushes a transmit word. If the FIFO is full and the engine does not pop in the same cycle, the word is dropped and raw bit1 (transmit overflow) sets. A push that coincides with an engine pop on a full FIFO is accepted.
- R6: A read of address 1 while the receive FIFO is empty returns 0 and sets raw bit2 (receive underflow).
- R7: An engine push into a full receive FIFO without a bus pop in the same cycle drops the word and sets raw bit3 (receive overflow). When a flag's set event and its clear fall in the same cycle, the flag stays set.
- R8: Writes to address 10 clear sticky flags: bit0 clears all three, bit1 clears receive underflow, bit2 clears receive overflow, bit3 clears transmit overflow. Flags not named in the write are left as they were.
- R9: Raw bit0 is high while the transmit level is at or below the transmit threshold (address 5). Raw bit4 is high while the receive level exceeds the receive threshold (address 6). Both follow the levels live.
- R10: Raw status reads at address 8. Masked status at address 9 equals raw AND the mask at address 7. The irq output is high when any masked bit is set.
- R11: Writes to addresses 5 and 6 are stored only when the value is below DEPTH; otherwise the old value is kept.
- R12: Address 11 holds the DMA enables: bit0 for receive, bit1 for transmit. dma_tx_req is high when transmit DMA is enabled and the transmit level is at or below the level at address 12. dma_rx_req is high when receive DMA is enabled and the receive level exceeds the level at address 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register selector |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| eng_busy | input | 1 | Serial engine is shifting |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | 16 | Oldest transmit word, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 16 | Received word |
| irq | output | 1 | OR of the masked interrupt vector |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Two pairs of events can fall in the same cycle: an engine push into a full receive FIFO while software clears the receive overflow flag, and an engine access on a full FIFO while the bus accesses the same FIFO. The bench drives both sides on the same clock edge. The first case is judged by the overflow flag staying set. The second is judged by the level staying at DEPTH, no flag rising, and the new word appearing at the tail when the FIFO is drained.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [3:0] {
    A_TXDATA  = 4'd0,
    A_RXDATA  = 4'd1,
    A_STATUS  = 4'd2,
    A_TXLVL   = 4'd3,
    A_RXLVL   = 4'd4,
    A_TXTHR   = 4'd5,
    A_RXTHR   = 4'd6,
    A_IMASK   = 4'd7,
    A_RAW     = 4'd8,
    A_MASKED  = 4'd9,
    A_ICLR    = 4'd10,
    A_DMACTL  = 4'd11,
    A_TXDMALV = 4'd12,
    A_RXDMALV = 4'd13
  } reg_addr_e;

  localparam int NUM_IRQ = 5;
  localparam int NUM_ST  = 5;

  localparam int IRQ_TX_LOW  = 0;
  localparam int IRQ_TX_OVF  = 1;
  localparam int IRQ_RX_UNF  = 2;
  localparam int IRQ_RX_OVF  = 3;
  localparam int IRQ_RX_HIGH = 4;

  localparam int CLR_ALL    = 0;
  localparam int CLR_RX_UNF = 1;
  localparam int CLR_RX_OVF = 2;
  localparam int CLR_TX_OVF = 3;

  localparam int DMA_RX_EN = 0;
  localparam int DMA_TX_EN = 1;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             unf
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [LVL_W-1:0] cnt, cnt_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt == LVL_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && (!full || pop);
  assign pop_ok  = pop && !empty;
  assign ovf     = push && full && !pop;
  assign unf     = pop && empty;
  assign level   = cnt;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt;
    if (push_ok) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt + 1'b1;
      2'b01:   cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_err_flags.sv
module spi_err_flags
  import spi_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_tx_ovf,
  input  logic       set_rx_unf,
  input  logic       set_rx_ovf,
  input  logic       clr_wr,
  input  logic [3:0] clr_bits,
  output logic       tx_ovf,
  output logic       rx_unf,
  output logic       rx_ovf
);
  logic clr_txo, clr_rxu, clr_rxo;
  logic tx_ovf_d, rx_unf_d, rx_ovf_d;

  assign clr_txo = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_TX_OVF]);
  assign clr_rxu = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_UNF]);
  assign clr_rxo = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_OVF]);

  always_comb begin
    tx_ovf_d = set_tx_ovf || (tx_ovf && !clr_txo);
    rx_unf_d = set_rx_unf || (rx_unf && !clr_rxu);
    rx_ovf_d = set_rx_ovf || (rx_ovf && !clr_rxo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_unf <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      tx_ovf <= tx_ovf_d;
      rx_unf <= rx_unf_d;
      rx_ovf <= rx_ovf_d;
    end
  end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              eng_busy,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  logic [LVL_W-1:0]   tx_lvl, rx_lvl;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic               tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev;
  logic [DATA_W-1:0]  rx_head;
  logic               wr_tx, rd_rx, wr_clr;
  logic               f_tx_ovf, f_rx_unf, f_rx_ovf;

  logic [PTR_W-1:0]   tx_thr, rx_thr, tx_thr_d, rx_thr_d;
  logic [NUM_IRQ-1:0] imask, imask_d;
  logic [1:0]         dmactl, dmactl_d;
  logic [LVL_W-1:0]   tx_dlvl, rx_dlvl, tx_dlvl_d, rx_dlvl_d;
  logic [NUM_IRQ-1:0] raw, masked;
  logic [NUM_ST-1:0]  status;
  logic               thr_ok;

  assign wr_tx  = wr_en && (addr == A_TXDATA);
  assign rd_rx  = rd_en && (addr == A_RXDATA);
  assign wr_clr = wr_en && (addr == A_ICLR);
  assign thr_ok = (wdata < DATA_W'(DEPTH));

  spi_word_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_tx), .pop(eng_tx_pop), .din(wdata),
    .dout(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf_ev), .unf(tx_unf_ev)
  );

  spi_word_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(eng_rx_push), .pop(rd_rx), .din(eng_rx_data),
    .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf_ev), .unf(rx_unf_ev)
  );

  spi_err_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_tx_ovf(tx_ovf_ev), .set_rx_unf(rx_unf_ev), .set_rx_ovf(rx_ovf_ev),
    .clr_wr(wr_clr), .clr_bits(wdata[3:0]),
    .tx_ovf(f_tx_ovf), .rx_unf(f_rx_unf), .rx_ovf(f_rx_ovf)
  );

  always_comb begin
    tx_thr_d  = tx_thr;
    rx_thr_d  = rx_thr;
    imask_d   = imask;
    dmactl_d  = dmactl;
    tx_dlvl_d = tx_dlvl;
    rx_dlvl_d = rx_dlvl;
    if (wr_en) begin
      case (addr)
        A_TXTHR:   if (thr_ok) tx_thr_d = wdata[PTR_W-1:0];
        A_RXTHR:   if (thr_ok) rx_thr_d = wdata[PTR_W-1:0];
        A_IMASK:   imask_d   = wdata[NUM_IRQ-1:0];
        A_DMACTL:  dmactl_d  = wdata[1:0];
        A_TXDMALV: tx_dlvl_d = wdata[LVL_W-1:0];
        A_RXDMALV: rx_dlvl_d = wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr  <= '0;
      rx_thr  <= '0;
      imask   <= '0;
      dmactl  <= '0;
      tx_dlvl <= '0;
      rx_dlvl <= '0;
    end else begin
      tx_thr  <= tx_thr_d;
      rx_thr  <= rx_thr_d;
      imask   <= imask_d;
      dmactl  <= dmactl_d;
      tx_dlvl <= tx_dlvl_d;
      rx_dlvl <= rx_dlvl_d;
    end
  end

  always_comb begin
    raw              = '0;
    raw[IRQ_TX_LOW]  = (tx_lvl <= LVL_W'(tx_thr));
    raw[IRQ_TX_OVF]  = f_tx_ovf;
    raw[IRQ_RX_UNF]  = f_rx_unf;
    raw[IRQ_RX_OVF]  = f_rx_ovf;
    raw[IRQ_RX_HIGH] = (rx_lvl > LVL_W'(rx_thr));
  end

  assign masked     = raw & imask;
  assign irq        = |masked;
  assign status     = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};
  assign dma_tx_req = dmactl[DMA_TX_EN] && (tx_lvl <= tx_dlvl);
  assign dma_rx_req = dmactl[DMA_RX_EN] && (rx_lvl > rx_dlvl);

  always_comb begin
    rdata = '0;
    case (addr)
      A_RXDATA:  rdata = rx_head;
      A_STATUS:  rdata = DATA_W'(status);
      A_TXLVL:   rdata = DATA_W'(tx_lvl);
      A_RXLVL:   rdata = DATA_W'(rx_lvl);
      A_TXTHR:   rdata = DATA_W'(tx_thr);
      A_RXTHR:   rdata = DATA_W'(rx_thr);
      A_IMASK:   rdata = DATA_W'(imask);
      A_RAW:     rdata = DATA_W'(raw);
      A_MASKED:  rdata = DATA_W'(masked);
      A_DMACTL:  rdata = DATA_W'(dmactl);
      A_TXDMALV: rdata = DATA_W'(tx_dlvl);
      A_RXDMALV: rdata = DATA_W'(rx_dlvl);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_ctrl_chk.sv
module spi_fifo_ctrl_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              eng_tx_pop,
  input logic              eng_rx_push,
  input logic [LVL_W-1:0]  tx_lvl,
  input logic [LVL_W-1:0]  rx_lvl,
  input logic [PTR_W-1:0]  tx_thr,
  input logic [NUM_IRQ-1:0] raw,
  input logic [NUM_ST-1:0] status,
  input logic              dma_rx_req
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  p_lvl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= FULL_LVL) && (rx_lvl <= FULL_LVL));

  p_full_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[3] && status[4]));

  p_tx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TXDATA && tx_lvl == FULL_LVL && !eng_tx_pop)
    |=> (raw[IRQ_TX_OVF] && tx_lvl == FULL_LVL));

  p_rx_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXDATA && rx_lvl == '0)
    |-> (rdata == '0) ##1 raw[IRQ_RX_UNF]);

  p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_lvl == FULL_LVL && !(rd_en && addr == A_RXDATA))
    |=> raw[IRQ_RX_OVF]);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ICLR && wdata[CLR_ALL] && !eng_rx_push && !rd_en)
    |=> (raw[3:1] == 3'b000));

  p_thr_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TXTHR && wdata >= DATA_W'(DEPTH)) |=> $stable(tx_thr));

  p_dma_rx_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> (rx_lvl != '0));
endmodule

bind spi_fifo_ctrl spi_fifo_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr), .raw(raw), .status(status),
  .dma_rx_req(dma_rx_req)
);

// File: tb/spi_fifo_ctrl_bench.sv
module spi_fifo_ctrl_bench;
  localparam int DEPTH = 32;
  localparam logic [3:0] TXDATA = 0, RXDATA = 1, STATUS = 2, TXLVL = 3, RXLVL = 4,
                         TXTHR = 5, RXTHR = 6, IMASK = 7, RAW = 8, MASKED = 9,
                         ICLR = 10, DMACTL = 11, TXDMALV = 12, RXDMALV = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic        eng_busy, eng_tx_pop, eng_rx_push;
  logic [15:0] eng_tx_data, eng_rx_data;
  logic        irq, dma_tx_req, dma_rx_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_ctrl u_spi_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    eng_busy = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic eng_push(input logic [15:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk); eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 tx level", TXLVL, 16'h0);
    rd_chk("R1 rx level", RXLVL, 16'h0);
    rd_chk("R1 raw", RAW, 16'h0001);
    rd_chk("R1 mask", IMASK, 16'h0);
    rd_chk("R1 dmactl", DMACTL, 16'h0);
    chk("R1 dma reqs", {14'h0, dma_tx_req, dma_rx_req}, 16'h0);
    rd_chk("R4 status idle", STATUS, 16'h000C);
    eng_busy = 1'b1;
    rd_chk("R4 status busy", STATUS, 16'h000D);
    eng_busy = 1'b0;
  endtask

  task automatic t_tx_order();
    do_reset();
    bus_wr(TXDATA, 16'h1111);
    bus_wr(TXDATA, 16'h2222);
    bus_wr(TXDATA, 16'h3333);
    rd_chk("R3 tx level 3", TXLVL, 16'd3);
    rd_chk("R4 status tx not empty", STATUS, 16'h0008);
    chk("R2 tx head 1", eng_tx_data, 16'h1111);
    eng_pop();
    chk("R2 tx head 2", eng_tx_data, 16'h2222);
    eng_pop();
    chk("R2 tx head 3", eng_tx_data, 16'h3333);
    eng_pop();
    rd_chk("R3 tx level 0", TXLVL, 16'd0);
  endtask

  task automatic t_tx_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) bus_wr(TXDATA, 16'h0100 + 16'(i));
    rd_chk("R4 status tx full", STATUS, 16'h000A);
    rd_chk("R3 tx level full", TXLVL, 16'(DEPTH));
    bus_wr(TXDATA, 16'hDEAD);
    rd_chk("R5 overflow raw", RAW, 16'h0002);
    rd_chk("R5 level after drop", TXLVL, 16'(DEPTH));
    bus_wr(ICLR, 16'h0008);
    rd_chk("R8 tx ovf cleared", RAW, 16'h0000);
    @(negedge clk); addr = TXDATA; wdata = 16'hBEEF; wr_en = 1'b1; eng_tx_pop = 1'b1;
    @(negedge clk); wr_en = 1'b0; eng_tx_pop = 1'b0;
    rd_chk("R5 push with pop no ovf", RAW, 16'h0000);
    rd_chk("R5 push with pop level", TXLVL, 16'(DEPTH));
    for (int i = 0; i < DEPTH - 1; i++) eng_pop();
    chk("R5 accepted word at tail", eng_tx_data, 16'hBEEF);
  endtask

  task automatic t_rx();
    do_reset();
    eng_push(16'h00A1);
    eng_push(16'h00A2);
    rd_chk("R3 rx level 2", RXLVL, 16'd2);
    rd_chk("R2 rx first", RXDATA, 16'h00A1);
    rd_chk("R2 rx second", RXDATA, 16'h00A2);
    rd_chk("R6 empty read zero", RXDATA, 16'h0000);
    rd_chk("R6 underflow raw", RAW, 16'h0005);
    for (int i = 0; i <= DEPTH; i++) eng_push(16'h0300 + 16'(i));
    rd_chk("R4 status rx full", STATUS, 16'h0014);
    rd_chk("R7 overflow raw", RAW, 16'h001D);
    bus_wr(ICLR, 16'h0002);
    rd_chk("R8 only underflow cleared", RAW, 16'h0019);
    bus_wr(ICLR, 16'h0001);
    rd_chk("R8 clear all", RAW, 16'h0011);
  endtask

  task automatic t_rx_collide();
    logic [15:0] d;
    do_reset();
    for (int i = 0; i <= DEPTH; i++) eng_push(16'h0200 + 16'(i));
    rd_chk("R7 overflow set", RAW, 16'h0019);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = 16'h6666;
    addr = ICLR; wdata = 16'h0004; wr_en = 1'b1;
    @(negedge clk); eng_rx_push = 1'b0; wr_en = 1'b0;
    rd_chk("R7 set beats clear", RAW, 16'h0019);
    bus_wr(ICLR, 16'h0004);
    rd_chk("R8 rx ovf cleared", RAW, 16'h0011);
    @(negedge clk); addr = RXDATA; rd_en = 1'b1; eng_rx_push = 1'b1; eng_rx_data = 16'h7777;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; eng_rx_push = 1'b0;
    chk("R2 pop head on full", d, 16'h0200);
    rd_chk("R7 push with pop no ovf", RAW, 16'h0011);
    rd_chk("R3 rx level kept", RXLVL, 16'(DEPTH));
    for (int i = 1; i < DEPTH; i++) bus_rd(RXDATA, d);
    chk("R2 rx last before tail", d, 16'h021F);
    rd_chk("R7 accepted word at tail", RXDATA, 16'h7777);
  endtask

  task automatic t_thresholds();
    do_reset();
    bus_wr(TXTHR, 16'd31);
    rd_chk("R11 tx thr 31 stored", TXTHR, 16'd31);
    bus_wr(TXTHR, 16'd32);
    rd_chk("R11 tx thr 32 refused", TXTHR, 16'd31);
    bus_wr(RXTHR, 16'd40);
    rd_chk("R11 rx thr 40 refused", RXTHR, 16'd0);
    bus_wr(TXTHR, 16'd2);
    bus_wr(RXTHR, 16'd1);
    bus_wr(TXDATA, 16'h1); bus_wr(TXDATA, 16'h2);
    rd_chk("R9 tx at thr", RAW, 16'h0001);
    bus_wr(TXDATA, 16'h3);
    rd_chk("R9 tx above thr", RAW, 16'h0000);
    eng_push(16'h5);
    rd_chk("R9 rx at thr", RAW, 16'h0000);
    eng_push(16'h6);
    rd_chk("R9 rx above thr", RAW, 16'h0010);
    bus_wr(IMASK, 16'h0011);
    rd_chk("R10 masked", MASKED, 16'h0010);
    chk("R10 irq high", {15'h0, irq}, 16'h1);
    bus_wr(IMASK, 16'h0001);
    rd_chk("R10 masked off", MASKED, 16'h0000);
    chk("R10 irq low", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_dma();
    do_reset();
    bus_wr(TXDATA, 16'h1); bus_wr(TXDATA, 16'h2); bus_wr(TXDATA, 16'h3);
    eng_push(16'h9);
    bus_wr(TXDMALV, 16'd1);
    chk("R12 disabled", {14'h0, dma_tx_req, dma_rx_req}, 16'h0);
    bus_wr(DMACTL, 16'h3);
    chk("R12 tx above level", {14'h0, dma_tx_req, dma_rx_req}, 16'h1);
    eng_pop(); eng_pop();
    chk("R12 tx at level", {14'h0, dma_tx_req, dma_rx_req}, 16'h3);
    bus_wr(RXDMALV, 16'd1);
    chk("R12 rx at level", {14'h0, dma_tx_req, dma_rx_req}, 16'h2);
    bus_wr(RXDMALV, 16'd0);
    bus_wr(DMACTL, 16'h1);
    chk("R12 tx disabled", {14'h0, dma_tx_req, dma_rx_req}, 16'h1);
    bus_wr(DMACTL, 16'h2);
    chk("R12 rx disabled", {14'h0, dma_tx_req, dma_rx_req}, 16'h2);
  endtask

  initial begin
    t_reset();
    t_tx_order();
    t_tx_overflow();
    t_rx();
    t_rx_collide();
    t_thresholds();
    t_dma();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule